// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host-to-PCI bridge. Software reaches it one byte at a time through an address, a write data byte, a write strobe and a registered read data byte. Every offset has its own write rule. Most offsets are plain storage with a mask of bits that may change. A few behave differently: one status byte is write-one-to-clear, the subsystem identity bytes are guarded by a key bit, and one control byte has a bit that always holds one. Offsets that have no rule ignore writes.

A synchronous reset loads the identity and default values. The bytes that steer the cache enables, the memory hole and top-of-memory decode, the system-management RAM window and the shadow ROM regions are brought out as side-band outputs. These outputs come straight from the storage flops, so they change on the same edge as the write that sets them.

Top module: `hb_cfg_space`

## Requirements
- R1: After reset, the identity bytes read as follows: 0x00=0xB9, 0x01=0x10, 0x02=0x31, 0x03=0x15, 0x04=0x06, 0x05=0x00, 0x06=0x00, 0x07=0x04, 0x08=0xB0, 0x0B=0x06 and 0x0D=0x20. Subsystem bytes 0x2C..0x2F repeat 0xB9, 0x10, 0x31, 0x15.
- R2: After reset, 0x41=0x08, 0x52=0xF0, 0x54=0xFF, 0x55=0xFF, 0x59=0x20, 0x5A=0x20 and 0x70=0x22. In 0x60..0x6F, even offsets hold 0x08 and odd offsets hold 0x40. Every other offset holds 0x00.
- R3: A masked write stores (data AND mask). The masks are 0x05:0x01, 0x0D:0xF8, 0x40:0xF1, 0x42:0xF7, 0x47:0xFC, 0x49:0x73, 0x57:0x60, 0x58:0x86, 0x5B:0x4F, 0x5D:0x53, 0x5F:0x7F, 0x72:0x0F, 0x74:0x2B, 0x80:0x84, 0x81:0x81 and 0x83:0x10. These offsets take all eight bits: 0x04, 0x43..0x46, 0x48, 0x4A, 0x4C..0x52, 0x54..0x56, 0x59, 0x5A, 0x5C, 0x60..0x71, 0x76 and 0x77.
- R4: A write to 0x07 clears each stored bit in positions 7:3 where the data bit is 1. Bits 2:0 never change on a write.
- R5: Offsets 0x2C..0x2F store a written byte only while bit 3 of offset 0x70 is 1. Otherwise the write is ignored. After reset they are locked.
- R6: A write to 0x41 stores (data AND 0xD6) OR 0x08, so bit 3 always reads 1.
- R7: l2_cache_en equals bit 0 of 0x42 and l1_cache_en equals bit 0 of 0x43. Both are 0 after reset.
- R8: The side-band outputs show stored bytes: mem_hole_cfg is 0x47, smram_cfg is 0x48, shadow_rd_en is {0x4D,0x4C} and shadow_wr_en is {0x4F,0x4E}.
- R9: Writes to offsets without a rule (for example 0x00, 0x06, 0x53, 0xFF) change nothing.
- R10: cfg_rdata shows the byte at the cfg_addr sampled on the previous rising edge. If that edge also wrote the same offset, cfg_rdata shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe |
| cfg_rdata | output | 8 | Registered read data |
| l2_cache_en | output | 1 | External cache enable |
| l1_cache_en | output | 1 | Internal cache enable |
| mem_hole_cfg | output | 8 | Memory hole / top-of-memory decode byte |
| smram_cfg | output | 8 | System-management RAM window byte |
| shadow_rd_en | output | 16 | Shadow region read enables |
| shadow_wr_en | output | 16 | Shadow region write enables |

## Verification
A write updates the stored byte and every side-band output on the same rising edge as the strobe. A read needs one further edge before its byte appears on cfg_rdata. The bench drives inputs on falling edges. It checks side-band outputs at the falling edge after the write edge. For a read, it presents the address at one falling edge and compares cfg_rdata at the next falling edge. The read-during-write case places the address and the strobe in the same cycle and expects the old byte one edge later.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_DW = 8;

  localparam logic [7:0] OFS_KEY    = 8'h70;
  localparam int unsigned KEY_BIT   = 3;
  localparam logic [7:0] OFS_L2     = 8'h42;
  localparam logic [7:0] OFS_L1     = 8'h43;
  localparam logic [7:0] OFS_HOLE   = 8'h47;
  localparam logic [7:0] OFS_SMRAM  = 8'h48;
  localparam logic [7:0] OFS_SHR_LO = 8'h4C;
  localparam logic [7:0] OFS_SHW_LO = 8'h4E;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_MASK,
    WK_W1C,
    WK_GATED,
    WK_FORCE
  } wkind_e;

  typedef struct packed {
    wkind_e     kind;
    logic [7:0] mask;
    logic [7:0] ones;
  } wrule_t;

  function automatic wrule_t rule_of(logic [7:0] a);
    wrule_t r;
    r = '{kind: WK_NONE, mask: 8'h00, ones: 8'h00};
    if ((a >= 8'h60 && a <= 8'h71) || (a >= 8'h4C && a <= 8'h52) ||
        (a >= 8'h43 && a <= 8'h46)) begin
      r.kind = WK_MASK; r.mask = 8'hFF;
    end else if (a >= 8'h2C && a <= 8'h2F) begin
      r.kind = WK_GATED; r.mask = 8'hFF;
    end else begin
      case (a)
        8'h04, 8'h48, 8'h4A, 8'h54, 8'h55, 8'h56,
        8'h59, 8'h5A, 8'h5C, 8'h76, 8'h77: begin r.kind = WK_MASK; r.mask = 8'hFF; end
        8'h05: begin r.kind = WK_MASK; r.mask = 8'h01; end
        8'h07: begin r.kind = WK_W1C;  r.mask = 8'hF8; end
        8'h0D: begin r.kind = WK_MASK; r.mask = 8'hF8; end
        8'h40: begin r.kind = WK_MASK; r.mask = 8'hF1; end
        8'h41: begin r.kind = WK_FORCE; r.mask = 8'hD6; r.ones = 8'h08; end
        8'h42: begin r.kind = WK_MASK; r.mask = 8'hF7; end
        8'h47: begin r.kind = WK_MASK; r.mask = 8'hFC; end
        8'h49: begin r.kind = WK_MASK; r.mask = 8'h73; end
        8'h57: begin r.kind = WK_MASK; r.mask = 8'h60; end
        8'h58: begin r.kind = WK_MASK; r.mask = 8'h86; end
        8'h5B: begin r.kind = WK_MASK; r.mask = 8'h4F; end
        8'h5D: begin r.kind = WK_MASK; r.mask = 8'h53; end
        8'h5F: begin r.kind = WK_MASK; r.mask = 8'h7F; end
        8'h72: begin r.kind = WK_MASK; r.mask = 8'h0F; end
        8'h74: begin r.kind = WK_MASK; r.mask = 8'h2B; end
        8'h80: begin r.kind = WK_MASK; r.mask = 8'h84; end
        8'h81: begin r.kind = WK_MASK; r.mask = 8'h81; end
        8'h83: begin r.kind = WK_MASK; r.mask = 8'h10; end
        default: r.kind = WK_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic logic [7:0] reset_value(logic [7:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a >= 8'h60 && a <= 8'h6F) begin
      v = a[0] ? 8'h40 : 8'h08;
    end else begin
      case (a)
        8'h00, 8'h2C: v = 8'hB9;
        8'h01, 8'h2D: v = 8'h10;
        8'h02, 8'h2E: v = 8'h31;
        8'h03, 8'h2F: v = 8'h15;
        8'h04:        v = 8'h06;
        8'h07:        v = 8'h04;
        8'h08:        v = 8'hB0;
        8'h0B:        v = 8'h06;
        8'h0D:        v = 8'h20;
        8'h41:        v = 8'h08;
        8'h52:        v = 8'hF0;
        8'h54, 8'h55: v = 8'hFF;
        8'h59, 8'h5A: v = 8'h20;
        8'h70:        v = 8'h22;
        default:      v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/hbcfg_wfilter.sv
module hbcfg_wfilter
  import hbcfg_pkg::*;
#(
  parameter int unsigned AW = CFG_AW,
  parameter int unsigned DW = CFG_DW
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cur,
  input  logic          key,
  output logic          upd,
  output logic [DW-1:0] nxt
);
  wrule_t rule;

  always_comb begin
    rule = rule_of(addr);
    upd  = 1'b0;
    nxt  = cur;
    case (rule.kind)
      WK_MASK: begin
        upd = 1'b1;
        nxt = wdata & rule.mask;
      end
      WK_W1C: begin
        upd = 1'b1;
        nxt = cur & ~(wdata & rule.mask);
      end
      WK_GATED: begin
        upd = key;
        nxt = wdata;
      end
      WK_FORCE: begin
        upd = 1'b1;
        nxt = (wdata & rule.mask) | rule.ones;
      end
      default: begin
        upd = 1'b0;
        nxt = cur;
      end
    endcase
  end
endmodule

// File: rtl/hbcfg_store.sv
module hbcfg_store
  import hbcfg_pkg::*;
#(
  parameter int unsigned AW = CFG_AW,
  parameter int unsigned DW = CFG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [DW-1:0] wval,
  output logic [DW-1:0] cur,
  output logic [DW-1:0] rdata,
  output logic          key,
  output logic [DW-1:0] b_l2,
  output logic [DW-1:0] b_l1,
  output logic [DW-1:0] b_hole,
  output logic [DW-1:0] b_smram,
  output logic [2*DW-1:0] b_shr,
  output logic [2*DW-1:0] b_shw
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= reset_value(8'(i));
      end
      rdata <= '0;
    end else begin
      if (wr) begin
        mem[addr] <= wval;
      end
      rdata <= mem[addr];
    end
  end

  assign cur     = mem[addr];
  assign key     = mem[OFS_KEY][KEY_BIT];
  assign b_l2    = mem[OFS_L2];
  assign b_l1    = mem[OFS_L1];
  assign b_hole  = mem[OFS_HOLE];
  assign b_smram = mem[OFS_SMRAM];
  assign b_shr   = {mem[OFS_SHR_LO + 8'd1], mem[OFS_SHR_LO]};
  assign b_shw   = {mem[OFS_SHW_LO + 8'd1], mem[OFS_SHW_LO]};
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hbcfg_pkg::*;
#(
  parameter int unsigned AW = CFG_AW,
  parameter int unsigned DW = CFG_DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  input  logic            cfg_we,
  output logic [DW-1:0]   cfg_rdata,
  output logic            l2_cache_en,
  output logic            l1_cache_en,
  output logic [DW-1:0]   mem_hole_cfg,
  output logic [DW-1:0]   smram_cfg,
  output logic [2*DW-1:0] shadow_rd_en,
  output logic [2*DW-1:0] shadow_wr_en
);
  logic [DW-1:0] cur_q;
  logic [DW-1:0] nxt_v;
  logic          upd_v;
  logic          key_q;
  logic [DW-1:0] l2_b;
  logic [DW-1:0] l1_b;

  hbcfg_wfilter #(.AW(AW), .DW(DW)) u_filt (
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cur   (cur_q),
    .key   (key_q),
    .upd   (upd_v),
    .nxt   (nxt_v)
  );

  hbcfg_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .addr    (cfg_addr),
    .wr      (cfg_we & upd_v),
    .wval    (nxt_v),
    .cur     (cur_q),
    .rdata   (cfg_rdata),
    .key     (key_q),
    .b_l2    (l2_b),
    .b_l1    (l1_b),
    .b_hole  (mem_hole_cfg),
    .b_smram (smram_cfg),
    .b_shr   (shadow_rd_en),
    .b_shw   (shadow_wr_en)
  );

  assign l2_cache_en = l2_b[0];
  assign l1_cache_en = l1_b[0];
endmodule

// File: rtl/hbcfg_chk.sv
module hbcfg_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   cfg_addr,
  input logic [DW-1:0]   cfg_wdata,
  input logic            cfg_we,
  input logic            l2_cache_en,
  input logic            l1_cache_en,
  input logic [DW-1:0]   mem_hole_cfg,
  input logic [DW-1:0]   smram_cfg
);
  AST_L2_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 8'h42) |=> (l2_cache_en == $past(cfg_wdata[0]))); // R7
  AST_L1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 8'h43) |=> (l1_cache_en == $past(cfg_wdata[0]))); // R7
  AST_CACHE_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!l2_cache_en && !l1_cache_en)); // R7
  AST_HOLE_MASK: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 8'h47) |=> (mem_hole_cfg == ($past(cfg_wdata) & 8'hFC))); // R3
  AST_SMRAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_addr == 8'h48) |=> $stable(smram_cfg)); // R8
endmodule

bind hb_cfg_space hbcfg_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_we       (cfg_we),
  .l2_cache_en  (l2_cache_en),
  .l1_cache_en  (l1_cache_en),
  .mem_hole_cfg (mem_hole_cfg),
  .smram_cfg    (smram_cfg)
);

// File: tb/sim_hb_cfg_space.sv
`timescale 1ns/1ps
module sim_hb_cfg_space;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic        l2_cache_en, l1_cache_en;
  logic [7:0]  mem_hole_cfg, smram_cfg;
  logic [15:0] shadow_rd_en, shadow_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_cfg_space u0 (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .l2_cache_en(l2_cache_en),
    .l1_cache_en(l1_cache_en), .mem_hole_cfg(mem_hole_cfg),
    .smram_cfg(smram_cfg), .shadow_rd_en(shadow_rd_en),
    .shadow_wr_en(shadow_wr_en)
  );

  // {offset, written byte, expected read-back}
  localparam logic [23:0] VEC [20] = '{
    {8'h05, 8'hFF, 8'h01},   // R3
    {8'h0D, 8'hFF, 8'hF8},   // R3
    {8'h40, 8'hFF, 8'hF1},   // R3
    {8'h49, 8'hFF, 8'h73},   // R3
    {8'h57, 8'hFF, 8'h60},   // R3
    {8'h72, 8'hFF, 8'h0F},   // R3
    {8'h5D, 8'hFF, 8'h53},   // R3
    {8'h83, 8'hFF, 8'h10},   // R3
    {8'h44, 8'h5A, 8'h5A},   // R3
    {8'h6F, 8'h12, 8'h12},   // R3
    {8'h41, 8'h00, 8'h08},   // R6
    {8'h41, 8'hFF, 8'hDE},   // R6
    {8'h07, 8'hFF, 8'h04},   // R4
    {8'h07, 8'h07, 8'h04},   // R4
    {8'h2C, 8'hAA, 8'hB9},   // R5 locked
    {8'h2F, 8'h00, 8'h15},   // R5 locked
    {8'h00, 8'h55, 8'hB9},   // R9
    {8'h06, 8'hFF, 8'h00},   // R9
    {8'h53, 8'h77, 8'h00},   // R9
    {8'hFF, 8'h3C, 8'h00}    // R9
  };

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_we = 1'b0;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    check(req, {8'h00, d}, {8'h00, exp});
  endtask

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 identity and subsystem defaults
    rd_check("R1", 8'h00, 8'hB9); rd_check("R1", 8'h01, 8'h10);
    rd_check("R1", 8'h02, 8'h31); rd_check("R1", 8'h03, 8'h15);
    rd_check("R1", 8'h04, 8'h06); rd_check("R1", 8'h07, 8'h04);
    rd_check("R1", 8'h08, 8'hB0); rd_check("R1", 8'h0B, 8'h06);
    rd_check("R1", 8'h0D, 8'h20); rd_check("R1", 8'h2C, 8'hB9);
    rd_check("R1", 8'h2D, 8'h10); rd_check("R1", 8'h2E, 8'h31);
    rd_check("R1", 8'h2F, 8'h15);
    // R2 remaining defaults
    rd_check("R2", 8'h41, 8'h08); rd_check("R2", 8'h52, 8'hF0);
    rd_check("R2", 8'h54, 8'hFF); rd_check("R2", 8'h55, 8'hFF);
    rd_check("R2", 8'h59, 8'h20); rd_check("R2", 8'h5A, 8'h20);
    rd_check("R2", 8'h70, 8'h22); rd_check("R2", 8'h53, 8'h00);
    rd_check("R2", 8'h44, 8'h00); rd_check("R2", 8'hFF, 8'h00);
    for (int i = 8'h60; i < 8'h70; i++) begin
      rd_check("R2", 8'(i), (i % 2 == 1) ? 8'h40 : 8'h08);
    end
    check("R7", {14'h0, l2_cache_en, l1_cache_en}, 16'h0);
    check("R8", shadow_rd_en, 16'h0000);

    // vector table: write then read back
    for (int k = 0; k < 20; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], d);
      check("R3/R4/R5/R6/R9 vector", {8'h00, d}, {8'h00, VEC[k][7:0]});
    end

    // R5 unlock, write, relock
    wr(8'h70, 8'h2A);
    wr(8'h2C, 8'hAA);
    rd_check("R5", 8'h2C, 8'hAA);
    wr(8'h70, 8'h22);
    wr(8'h2D, 8'hCC);
    rd_check("R5", 8'h2D, 8'h10);
    rd_check("R5", 8'h2C, 8'hAA);

    // R7 cache enables, due at the falling edge after the write edge
    wr(8'h42, 8'h01);
    check("R7 l2", {15'h0, l2_cache_en}, 16'h1);
    wr(8'h43, 8'hFE);
    check("R7 l1", {15'h0, l1_cache_en}, 16'h0);
    wr(8'h43, 8'h01);
    check("R7 l1", {15'h0, l1_cache_en}, 16'h1);
    wr(8'h42, 8'hFE);
    check("R7 l2", {15'h0, l2_cache_en}, 16'h0);

    // R8 decoder bytes
    wr(8'h47, 8'hFF);
    check("R8 hole", {8'h0, mem_hole_cfg}, 16'h00FC);
    wr(8'h48, 8'hA5);
    check("R8 smram", {8'h0, smram_cfg}, 16'h00A5);
    wr(8'h4C, 8'h11); wr(8'h4D, 8'h22); wr(8'h4E, 8'h33); wr(8'h4F, 8'h44);
    check("R8 shadow rd", shadow_rd_en, 16'h2211);
    check("R8 shadow wr", shadow_wr_en, 16'h4433);

    // R10 read during write returns the old byte
    @(negedge clk);
    cfg_addr = 8'h44; cfg_wdata = 8'h99; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R10 old", {8'h0, cfg_rdata}, 16'h005A);
    @(negedge clk);
    check("R10 new", {8'h0, cfg_rdata}, 16'h0099);

    // reset restores defaults
    do_reset();
    rd_check("R1", 8'h2C, 8'hB9);
    rd_check("R2", 8'h44, 8'h00);
    rd_check("R2", 8'h41, 8'h08);
    check("R7", {14'h0, l2_cache_en, l1_cache_en}, 16'h0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule